// File: doc/BRIEF.md
# Eight-Channel Pulse-Width Modulator with Pair Joining

This block drives eight pulse-width modulated outputs. Each channel has its own 8-bit counter, period and duty value. Each channel can run left-aligned or center-aligned. Neighbouring channels (0 with 1, 2 with 3, 4 with 5, 6 with 7) can be joined into a single 16-bit channel, so that long periods need no prescaler. All counters advance only on a single-cycle count-enable input `tick`, which stands in for the channel clock.

Software reaches the block through a flat register port. Writes take effect at the clock edge and reads are combinational. Period and duty writes go to holding registers. A channel copies them into its working registers only at the end of a period, or while it is disabled. This way a write never produces a cut or stretched pulse.

Top module: `pwm_bank`

## Requirements
- R1: Register map (address = bank in `reg_addr[4:3]`, index in `reg_addr[2:0]`). Bank 0 holds control: index 0 is the alignment mask (bit n = 1 makes channel n center-aligned), index 1 is the join mask (bit k joins channels 2k and 2k+1), index 2 is the enable mask, and index 3 is the polarity mask. Bank 1 index n is the period of channel n. Bank 2 index n is the duty of channel n. Every register reads back what was last written, and all of them reset to 0.
- R2: Left-aligned mode: the count runs 0, 1, … period−1 and then returns to 0. The output is at its active level while count < duty.
- R3: Center-aligned mode: the count runs up from 0 to period and back down to 1, then restarts at 0, so one cycle lasts 2×period ticks. The output is active while count < duty.
- R4: A duty of 0 keeps the output inactive for the whole cycle. A duty ≥ period (with duty ≠ 0) keeps it active for the whole cycle, in both modes.
- R5: In a joined pair, the even channel's period and duty registers supply the high byte and the odd channel's registers supply the low byte of the 16-bit values. The waveform appears on the odd output, and the even output is held at its inactive level.
- R6: A joined pair takes its enable, alignment and polarity from the odd channel's bits. The even channel's enable and alignment bits have no effect on the pair.
- R7: A period or duty written while a channel runs takes effect at the first count of the next period. The current period completes with the old values.
- R8: Polarity bit 1 makes the active level high; bit 0 makes it low. A disabled channel outputs the inactive level (the inverse of its polarity bit) and its count returns to 0. On re-enable the channel starts from count 0 with the current holding values.
- R9: Counters advance only in cycles where `tick` is 1. Without `tick` and without register writes, the outputs do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Count enable for all channel counters |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register address (bank, index) |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` |
| pwm_out | output | 8 | Channel outputs, bit n for channel n |

## Verification
The bench uses the default eight channels and 8-bit counters, so every address bit and every pair is real. With a 16-bit period of 258 (high byte 1), a joined pair crosses the low-byte carry within about 500 ticks. A 256 period in center mode takes the joined counter up through the carry and back down through the borrow. Short 8-bit periods of 3 to 5 allow the complete waveform of each mode to be compared tick by tick. They also allow the duty extremes, mid-period writes and disable and re-enable events to be placed on exact counts.

// File: rtl/pwm_bank.sv
module pwm_bank #(
  parameter int NCH = 8,
  parameter int DW  = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick,
  input  logic                reg_we,
  input  logic [$clog2(NCH)+1:0] reg_addr,
  input  logic [((NCH > DW) ? NCH : DW)-1:0] reg_wdata,
  output logic [((NCH > DW) ? NCH : DW)-1:0] reg_rdata,
  output logic [NCH-1:0]      pwm_out
);
  localparam int NP = NCH / 2;
  localparam int CW = 2 * DW;
  localparam int IW = $clog2(NCH);
  localparam int AW = IW + 2;
  localparam int RW = (NCH > DW) ? NCH : DW;

  logic [NCH-1:0] align_r, en_r, pol_r;
  logic [NP-1:0]  join_r;
  logic [DW-1:0]  per_h  [NCH];
  logic [DW-1:0]  duty_h [NCH];

  logic [1:0]    bank;
  logic [IW-1:0] idx;
  assign bank = reg_addr[AW-1 -: 2];
  assign idx  = reg_addr[IW-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      align_r <= '0;
      en_r    <= '0;
      pol_r   <= '0;
      join_r  <= '0;
      for (int i = 0; i < NCH; i++) begin
        per_h[i]  <= '0;
        duty_h[i] <= '0;
      end
    end else if (reg_we) begin
      case (bank)
        2'd0: begin
          if (idx == IW'(0)) align_r <= reg_wdata[NCH-1:0];
          if (idx == IW'(1)) join_r  <= reg_wdata[NP-1:0];
          if (idx == IW'(2)) en_r    <= reg_wdata[NCH-1:0];
          if (idx == IW'(3)) pol_r   <= reg_wdata[NCH-1:0];
        end
        2'd1: per_h[idx]  <= reg_wdata[DW-1:0];
        2'd2: duty_h[idx] <= reg_wdata[DW-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (bank)
      2'd0: begin
        if (idx == IW'(0)) reg_rdata[NCH-1:0] = align_r;
        if (idx == IW'(1)) reg_rdata[NP-1:0]  = join_r;
        if (idx == IW'(2)) reg_rdata[NCH-1:0] = en_r;
        if (idx == IW'(3)) reg_rdata[NCH-1:0] = pol_r;
      end
      2'd1: reg_rdata[DW-1:0] = per_h[idx];
      2'd2: reg_rdata[DW-1:0] = duty_h[idx];
      default: ;
    endcase
  end

  // returns {end_of_period, next_dir, next_count}
  function automatic logic [DW+1:0] step_n(input logic [DW-1:0] c, input logic [DW-1:0] p,
                                           input logic d, input logic cen);
    logic [DW-1:0] n;
    logic nd, e;
    n = c; nd = d; e = 1'b0;
    if (!cen) begin
      nd = 1'b0;
      if (p == '0 || c >= p - DW'(1)) begin n = '0; e = 1'b1; end
      else n = c + DW'(1);
    end else if (!d) begin
      if ({1'b0, c} + (DW+1)'(1) >= {1'b0, p}) begin n = p; nd = 1'b1; end
      else n = c + DW'(1);
    end else begin
      if (c <= DW'(1)) begin n = '0; nd = 1'b0; e = 1'b1; end
      else n = c - DW'(1);
    end
    return {e, nd, n};
  endfunction

  function automatic logic [CW+1:0] step_w(input logic [CW-1:0] c, input logic [CW-1:0] p,
                                           input logic d, input logic cen);
    logic [CW-1:0] n;
    logic nd, e;
    n = c; nd = d; e = 1'b0;
    if (!cen) begin
      nd = 1'b0;
      if (p == '0 || c >= p - CW'(1)) begin n = '0; e = 1'b1; end
      else n = c + CW'(1);
    end else if (!d) begin
      if ({1'b0, c} + (CW+1)'(1) >= {1'b0, p}) begin n = p; nd = 1'b1; end
      else n = c + CW'(1);
    end else begin
      if (c <= CW'(1)) begin n = '0; nd = 1'b0; e = 1'b1; end
      else n = c - CW'(1);
    end
    return {e, nd, n};
  endfunction

  for (genvar p = 0; p < NP; p++) begin : g_pair
    localparam int E = 2 * p;
    localparam int O = 2 * p + 1;

    logic [DW-1:0] cnt_e, cnt_o, pa_e, pa_o, da_e, da_o;
    logic          dir_e, dir_o;
    logic [DW+1:0] st_e, st_o;
    logic [CW+1:0] st_j;
    logic [CW-1:0] cnt_j, pa_j, da_j;
    logic          act_e, act_o, act_j;

    assign cnt_j = {cnt_e, cnt_o};
    assign pa_j  = {pa_e, pa_o};
    assign da_j  = {da_e, da_o};

    assign st_e = step_n(cnt_e, pa_e, dir_e, align_r[E]);
    assign st_o = step_n(cnt_o, pa_o, dir_o, align_r[O]);
    assign st_j = step_w(cnt_j, pa_j, dir_o, align_r[O]);

    assign act_e = (da_e != '0) && (da_e >= pa_e || cnt_e < da_e);
    assign act_o = (da_o != '0) && (da_o >= pa_o || cnt_o < da_o);
    assign act_j = (da_j != '0) && (da_j >= pa_j || cnt_j < da_j);

    assign pwm_out[E] = (!join_r[p] && en_r[E] && act_e) ? pol_r[E] : ~pol_r[E];
    assign pwm_out[O] = (en_r[O] && (join_r[p] ? act_j : act_o)) ? pol_r[O] : ~pol_r[O];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cnt_e <= '0; cnt_o <= '0;
        pa_e  <= '0; pa_o  <= '0;
        da_e  <= '0; da_o  <= '0;
        dir_e <= 1'b0; dir_o <= 1'b0;
      end else if (join_r[p]) begin
        dir_e <= 1'b0;
        if (!en_r[O]) begin
          cnt_e <= '0; cnt_o <= '0; dir_o <= 1'b0;
          pa_e <= per_h[E]; pa_o <= per_h[O];
          da_e <= duty_h[E]; da_o <= duty_h[O];
        end else if (tick) begin
          {cnt_e, cnt_o} <= st_j[CW-1:0];
          dir_o <= st_j[CW];
          if (st_j[CW+1]) begin
            pa_e <= per_h[E]; pa_o <= per_h[O];
            da_e <= duty_h[E]; da_o <= duty_h[O];
          end
        end
      end else begin
        if (!en_r[E]) begin
          cnt_e <= '0; dir_e <= 1'b0;
          pa_e <= per_h[E]; da_e <= duty_h[E];
        end else if (tick) begin
          cnt_e <= st_e[DW-1:0];
          dir_e <= st_e[DW];
          if (st_e[DW+1]) begin pa_e <= per_h[E]; da_e <= duty_h[E]; end
        end
        if (!en_r[O]) begin
          cnt_o <= '0; dir_o <= 1'b0;
          pa_o <= per_h[O]; da_o <= duty_h[O];
        end else if (tick) begin
          cnt_o <= st_o[DW-1:0];
          dir_o <= st_o[DW];
          if (st_o[DW+1]) begin pa_o <= per_h[O]; da_o <= duty_h[O]; end
        end
      end
    end
  end
endmodule

// File: rtl/pwm_bank_chk.sv
module pwm_bank_chk #(
  parameter int NCH = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             reg_we,
  input logic [NCH-1:0]   pwm_out,
  input logic [NCH-1:0]   en_r,
  input logic [NCH-1:0]   pol_r,
  input logic [NCH/2-1:0] join_r
);
  // R9
  hold_without_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !reg_we) |=> $stable(pwm_out));

  // R1
  ctrl_write_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_we |=> ($stable(join_r) && $stable(en_r) && $stable(pol_r)));

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    if (c % 2 == 1) begin : g_odd
      // R8
      odd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en_r[c] |-> (pwm_out[c] == ~pol_r[c]));
    end else begin : g_even
      // R8
      even_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!join_r[c/2] && !en_r[c]) |-> (pwm_out[c] == ~pol_r[c]));
      // R5
      even_joined_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        join_r[c/2] |-> (pwm_out[c] == ~pol_r[c]));
    end
  end
endmodule

bind pwm_bank pwm_bank_chk #(.NCH(NCH)) u_chk (.*);

// File: tb/pwm_bank_test.sv
`timescale 1ns/1ps
module pwm_bank_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       reg_we = 1'b0;
  logic [4:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic [7:0] pwm_out;

  int  n_chk = 0;
  int  n_bad = 0;
  bit  done = 1'b0;

  localparam logic [4:0] A_ALIGN = 5'd0, A_JOIN = 5'd1, A_EN = 5'd2, A_POL = 5'd3;

  always #2.5 clk = ~clk;

  pwm_bank uut (.clk(clk), .rst_n(rst_n), .tick(tick), .reg_we(reg_we),
                .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
                .pwm_out(pwm_out));

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [4:0] a, input logic [7:0] exp);
    @(negedge clk);
    reg_addr = a;
    #1;
    chk(req, reg_rdata, exp);
  endtask

  task automatic pulse();
    @(negedge clk);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  function automatic bit exp_left(input int i, input int per, input int duty);
    int c;
    c = (per == 0) ? 0 : i % per;
    return (duty != 0) && (duty >= per || c < duty);
  endfunction

  function automatic bit exp_ctr(input int i, input int per, input int duty);
    int pos, c;
    pos = i % (2 * per);
    c = (pos <= per) ? pos : 2 * per - pos;
    return (duty != 0) && (duty >= per || c < duty);
  endfunction

  task automatic t_reset();
    chk("R8 reset outputs inactive high", pwm_out, 8'hFF);
    rd_chk("R1 align reset", A_ALIGN, 8'h00);
    rd_chk("R1 join reset", A_JOIN, 8'h00);
    rd_chk("R1 enable reset", A_EN, 8'h00);
    rd_chk("R1 period reset", 5'd8 + 5'd5, 8'h00);
    wr(A_POL, 8'hFF);
    chk("R8 polarity high idles low", pwm_out, 8'h00);
    wr(A_ALIGN, 8'hA5);
    rd_chk("R1 align readback", A_ALIGN, 8'hA5);
    wr(5'd16 + 5'd6, 8'h3C);
    rd_chk("R1 duty readback", 5'd16 + 5'd6, 8'h3C);
    wr(A_ALIGN, 8'h00);
    wr(5'd16 + 5'd6, 8'h00);
  endtask

  task automatic t_left();
    wr(5'd8, 8'd5);
    wr(5'd16, 8'd2);
    wr(A_EN, 8'h01);
    for (int i = 0; i < 12; i++) begin
      chk("R2 left waveform", pwm_out[0], exp_left(i, 5, 2));
      pulse();
    end
    repeat (6) @(negedge clk);
    chk("R9 no tick keeps output", pwm_out[0], exp_left(12, 5, 2));
    for (int i = 12; i < 16; i++) begin
      chk("R9 count resumes without skip", pwm_out[0], exp_left(i, 5, 2));
      pulse();
    end
  endtask

  task automatic t_center();
    wr(A_EN, 8'h00);
    wr(A_ALIGN, 8'h02);
    wr(5'd9, 8'd4);
    wr(5'd17, 8'd2);
    wr(A_EN, 8'h02);
    for (int i = 0; i < 17; i++) begin
      chk("R3 center waveform", pwm_out[1], exp_ctr(i, 4, 2));
      pulse();
    end
  endtask

  task automatic t_extremes();
    wr(A_EN, 8'h00);
    wr(A_ALIGN, 8'h08);
    wr(5'd10, 8'd3);
    wr(5'd18, 8'd0);
    wr(5'd11, 8'd3);
    wr(5'd19, 8'd5);
    wr(A_EN, 8'h0C);
    for (int i = 0; i < 8; i++) begin
      chk("R4 duty zero never active", pwm_out[2], 0);
      chk("R4 duty above period always active", pwm_out[3], 1);
      pulse();
    end
  endtask

  task automatic t_update();
    wr(A_EN, 8'h00);
    chk("R8 all disabled idle", pwm_out, 8'h00);
    wr(A_ALIGN, 8'h00);
    wr(5'd8, 8'd5);
    wr(5'd16, 8'd2);
    wr(A_EN, 8'h01);
    pulse();
    pulse();
    wr(5'd16, 8'd4);
    for (int i = 2; i < 5; i++) begin
      chk("R7 old duty until period end", pwm_out[0], exp_left(i, 5, 2));
      pulse();
    end
    for (int i = 0; i < 5; i++) begin
      chk("R7 new duty from next period", pwm_out[0], exp_left(i, 5, 4));
      pulse();
    end
  endtask

  task automatic t_disable();
    pulse();
    pulse();
    wr(A_EN, 8'h00);
    chk("R8 disabled output inactive", pwm_out[0], 0);
    wr(A_POL, 8'hFE);
    chk("R8 disabled low polarity idles high", pwm_out[0], 1);
    wr(A_EN, 8'h01);
    for (int i = 0; i < 6; i++) begin
      chk("R8 restart from zero, inverted", pwm_out[0], !exp_left(i, 5, 4));
      pulse();
    end
    wr(A_EN, 8'h00);
    wr(A_POL, 8'hFF);
  endtask

  task automatic t_join_left();
    wr(A_JOIN, 8'h04);
    wr(A_ALIGN, 8'h10);
    wr(5'd12, 8'd1);
    wr(5'd13, 8'd2);
    wr(5'd20, 8'd1);
    wr(5'd21, 8'd1);
    wr(A_EN, 8'h10);
    for (int i = 0; i < 3; i++) pulse();
    chk("R6 even enable ignored when joined", pwm_out[5:4], 0);
    wr(A_EN, 8'h30);
    for (int i = 0; i < 521; i++) begin
      chk("R5 joined left waveform on odd", pwm_out[5], exp_left(i, 258, 257));
      chk("R5 even output held inactive", pwm_out[4], 0);
      pulse();
    end
    wr(A_EN, 8'h00);
  endtask

  task automatic t_join_center();
    wr(A_JOIN, 8'h08);
    wr(A_ALIGN, 8'h80);
    wr(5'd14, 8'd1);
    wr(5'd15, 8'd0);
    wr(5'd22, 8'd0);
    wr(5'd23, 8'h80);
    wr(A_EN, 8'h80);
    for (int i = 0; i < 521; i++) begin
      chk("R6 joined center by odd align bit", pwm_out[7], exp_ctr(i, 256, 128));
      pulse();
    end
    chk("R5 even output of joined pair", pwm_out[6], 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_left();
    t_center();
    t_extremes();
    t_update();
    t_disable();
    t_join_left();
    t_join_center();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule